// File: doc/BRIEF.md
# Programmable Clock Output Divider Channel

This block forms a single clock output of a programmable clock generator. It runs on a fast source clock and produces one output clock. A 2-bit divide mode selects the output function: off, a straight pass-through of the source, a divide-by-2, or a divide-by-(Q+2) with a 10-bit Q. Two complete configuration sets, each holding a Q value and a divide mode, are presented at the ports. A select input picks the live set. A change of set or of divide parameters waits for the start of the next output period, so no runt pulse is produced.

The output is live only when the channel enable is high and the divide modes of both sets are non-zero. Otherwise the divider is held at zero and the pin goes to a safe state chosen by a 2-bit park field: high-impedance, driven low, or driven high. An inversion bit flips the polarity of the live clock. It does not alter a parked level. A separate drive-enable output controls the pad's tri-state buffer.

Top module: `outdiv_channel`

## Requirements
- R1: While `rst` is high, the divider is not running. The pin then shows the parked state selected by `park_mode`. With `park_mode` = 00 this means `drive_en` = 0 and `clk_out` = 0.
- R2: The channel runs only when `out_en` = 1, `mode_set0` != 00 and `mode_set1` != 00. If any of these conditions fails at a source clock edge, the output is parked from that edge on. While running, `drive_en` is 1.
- R3: While parked, `park_mode` sets the pin. With 00 or 01 the result is `drive_en` = 0 and `clk_out` = 0. With 10 the result is `drive_en` = 1 and `clk_out` = 0. With 11 the result is `drive_en` = 1 and `clk_out` = 1.
- R4: With the active divide mode at 01, `clk_out` follows the source clock level (XOR `invert`).
- R5: With the active divide mode at 10, `clk_out` is high for one source cycle, then low for one, and repeats.
- R6: With the active divide mode at 11, the output period is N = Q+2 source cycles. Each period starts with floor(N/2) high cycles, and the remaining cycles are low. Q ranges over 0 to 1023.
- R7: `invert` = 1 inverts the running output. A parked level is emitted as requested, whatever the value of `invert`.
- R8: `set_sel` (0 picks set 0, 1 picks set 1), and the Q and mode fields of the chosen set, are sampled only at the edge that starts an output period. A change made during a period leaves the rest of that period unchanged.
- R9: After the run condition becomes true at an edge, the output starts a fresh period on that edge. The count starts from zero and the output begins with its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Channel enable |
| set_sel | input | 1 | Configuration set select (0 or 1) |
| mode_set0 | input | 2 | Divide mode of set 0 (00 off, 01 by 1, 10 by 2, 11 by Q+2) |
| q_set0 | input | 10 | Q value of set 0 |
| mode_set1 | input | 2 | Divide mode of set 1 |
| q_set1 | input | 10 | Q value of set 1 |
| park_mode | input | 2 | Disabled pin state (0x high-Z, 10 low, 11 high) |
| invert | input | 1 | Invert the running output |
| clk_out | output | 1 | Output clock level |
| drive_en | output | 1 | Pad drive enable, 0 means high-impedance |

## Verification
Several properties are checked on every cycle. The parked pin state must follow `park_mode`, with no inversion applied. `drive_en` must be high whenever the divider runs. A failed run condition must stop the divider on the next edge. The period count must stay below the active ratio. A restart must begin at count zero in the high phase. The latched ratio must hold steady inside a period. The exact waveform shapes can only be shown by the bench scenarios: high and low lengths for odd and even ratios up to 1025, the pass-through levels on both clock phases, the polarity flip, and the deferred effect of a mid-period set switch. The bench compares these cycle by cycle against its own model.

// File: rtl/outdiv_pkg.sv
package outdiv_pkg;

    typedef enum logic [1:0] {
        DM_OFF  = 2'b00,
        DM_PASS = 2'b01,
        DM_DIV2 = 2'b10,
        DM_DIVQ = 2'b11
    } div_mode_e;

    typedef enum logic [1:0] {
        PK_HIZ_A = 2'b00,
        PK_HIZ_B = 2'b01,
        PK_LOW   = 2'b10,
        PK_HIGH  = 2'b11
    } park_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    // Division ratio for one configuration; zero for the off mode.
    function automatic int unsigned ratio_of(div_mode_e m, int unsigned q);
        case (m)
            DM_PASS: return 1;
            DM_DIV2: return 2;
            DM_DIVQ: return q + 2;
            default: return 0;
        endcase
    endfunction

    // High phase length: the smaller half of the ratio.
    function automatic int unsigned high_len(int unsigned n);
        return n >> 1;
    endfunction

    // Pin state while the divider is stopped; literal level, no inversion.
    function automatic pin_t park_pin(park_e p);
        pin_t r;
        case (p)
            PK_LOW:  begin r.drive = 1'b1; r.level = 1'b0; end
            PK_HIGH: begin r.drive = 1'b1; r.level = 1'b1; end
            default: begin r.drive = 1'b0; r.level = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/outdiv_cfg_sel.sv
module outdiv_cfg_sel
    import outdiv_pkg::*;
#(
    parameter int QW    = 10,
    parameter int NSETS = 2,
    parameter int CW    = QW + 1,
    parameter int SW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic [NSETS*QW-1:0] q_flat,
    input  logic [NSETS*2-1:0]  mode_flat,
    input  logic [SW-1:0]       sel,
    output logic                all_on,
    output logic [CW-1:0]       n_next,
    output logic [CW-1:0]       hi_next,
    output logic                bypass_next
);

    div_mode_e       mode_arr [NSETS];
    logic [QW-1:0]   q_arr    [NSETS];
    logic [NSETS-1:0] nz;

    for (genvar i = 0; i < NSETS; i++) begin : g_set
        assign mode_arr[i] = div_mode_e'(mode_flat[i*2 +: 2]);
        assign q_arr[i]    = q_flat[i*QW +: QW];
        assign nz[i]       = (mode_arr[i] != DM_OFF);
    end

    assign all_on = &nz;

    div_mode_e     sel_mode;
    logic [QW-1:0] sel_q;
    logic [31:0]   ratio_w;
    logic [31:0]   high_w;

    always_comb begin
        sel_mode    = mode_arr[sel];
        sel_q       = q_arr[sel];
        ratio_w     = ratio_of(sel_mode, 32'(sel_q));
        high_w      = high_len(ratio_w);
        n_next      = ratio_w[CW-1:0];
        hi_next     = high_w[CW-1:0];
        bypass_next = (sel_mode == DM_PASS);
    end

endmodule

// File: rtl/outdiv_counter.sv
module outdiv_counter #(
    parameter int CW    = 11,
    parameter int DEF_N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] n_next,
    input  logic [CW-1:0] hi_next,
    input  logic          bypass_next,
    output logic          running,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] act_n,
    output logic          bypass,
    output logic          div_q
);

    localparam logic [CW-1:0] DEF_N_V  = CW'(DEF_N);
    localparam logic [CW-1:0] DEF_HI_V = CW'(DEF_N / 2);

    logic [CW-1:0] act_hi;
    logic          period_end;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc    = cnt + 1'b1;
    assign period_end = !running || bypass || (cnt == act_n - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            running <= 1'b0;
            cnt     <= '0;
            act_n   <= DEF_N_V;
            act_hi  <= DEF_HI_V;
            bypass  <= 1'b0;
            div_q   <= 1'b0;
        end else if (period_end) begin
            running <= 1'b1;
            cnt     <= '0;
            act_n   <= n_next;
            act_hi  <= hi_next;
            bypass  <= bypass_next;
            div_q   <= 1'b1;
        end else begin
            cnt     <= cnt_inc;
            div_q   <= (cnt_inc < act_hi);
        end
    end

endmodule

// File: rtl/outdiv_out_stage.sv
module outdiv_out_stage
    import outdiv_pkg::*;
(
    input  logic  clk,
    input  logic  running,
    input  logic  bypass,
    input  logic  div_q,
    input  park_e park,
    input  logic  invert,
    output logic  clk_out,
    output logic  drive_en
);

    pin_t parked;
    logic live_lvl;

    always_comb begin
        parked   = park_pin(park);
        live_lvl = bypass ? clk : div_q;
        if (running) begin
            drive_en = 1'b1;
            clk_out  = live_lvl ^ invert;
        end else begin
            drive_en = parked.drive;
            clk_out  = parked.level;
        end
    end

endmodule

// File: rtl/outdiv_channel.sv
module outdiv_channel
    import outdiv_pkg::*;
#(
    parameter int QW    = 10,
    parameter int DEF_Q = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          out_en,
    input  logic          set_sel,
    input  logic [1:0]    mode_set0,
    input  logic [QW-1:0] q_set0,
    input  logic [1:0]    mode_set1,
    input  logic [QW-1:0] q_set1,
    input  logic [1:0]    park_mode,
    input  logic          invert,
    output logic          clk_out,
    output logic          drive_en
);

    localparam int NSETS = 2;
    localparam int CW    = QW + 1;

    logic          all_on;
    logic          en_live;
    logic [CW-1:0] n_next;
    logic [CW-1:0] hi_next;
    logic          bypass_next;
    logic          running;
    logic [CW-1:0] cnt;
    logic [CW-1:0] act_n;
    logic          bypass;
    logic          div_q;

    outdiv_cfg_sel #(.QW(QW), .NSETS(NSETS), .CW(CW), .SW(1)) u_sel (
        .q_flat      ({q_set1, q_set0}),
        .mode_flat   ({mode_set1, mode_set0}),
        .sel         (set_sel),
        .all_on      (all_on),
        .n_next      (n_next),
        .hi_next     (hi_next),
        .bypass_next (bypass_next)
    );

    assign en_live = out_en && all_on;

    outdiv_counter #(.CW(CW), .DEF_N(DEF_Q + 2)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .en          (en_live),
        .n_next      (n_next),
        .hi_next     (hi_next),
        .bypass_next (bypass_next),
        .running     (running),
        .cnt         (cnt),
        .act_n       (act_n),
        .bypass      (bypass),
        .div_q       (div_q)
    );

    outdiv_out_stage u_out (
        .clk      (clk),
        .running  (running),
        .bypass   (bypass),
        .div_q    (div_q),
        .park     (park_e'(park_mode)),
        .invert   (invert),
        .clk_out  (clk_out),
        .drive_en (drive_en)
    );

endmodule

// File: rtl/outdiv_channel_chk.sv
module outdiv_channel_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          running,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] act_n,
    input logic          div_q,
    input logic [1:0]    park_mode,
    input logic          drive_en,
    input logic          clk_out
);

    assert_parked_drive_R3: assert property (@(posedge clk) disable iff (rst)
        !running |-> (drive_en == park_mode[1]));

    // R7: parked level is literal, never inverted
    assert_parked_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!running && park_mode[1]) |-> (clk_out == park_mode[0]));

    assert_live_drive_R2: assert property (@(posedge clk) disable iff (rst)
        running |-> drive_en);

    assert_gate_stop_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !running);

    assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < act_n));

    assert_fresh_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (cnt == '0 && div_q));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != '0) |-> $stable(act_n));

endmodule

bind outdiv_channel outdiv_channel_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en_live),
    .running   (running),
    .cnt       (cnt),
    .act_n     (act_n),
    .div_q     (div_q),
    .park_mode (park_mode),
    .drive_en  (drive_en),
    .clk_out   (clk_out)
);

// File: tb/tb_outdiv_channel.sv
module tb_outdiv_channel;

    logic       clk = 1'b0;
    logic       rst;
    logic       out_en;
    logic       set_sel;
    logic [1:0] mode_set0, mode_set1;
    logic [9:0] q_set0, q_set1;
    logic [1:0] park_mode;
    logic       invert;
    logic       clk_out, drive_en;

    int    checks = 0;
    int    errors = 0;
    string tag_ovr = "";
    bit    done = 1'b0;

    // reference model state
    bit m_run = 1'b0;
    bit m_byp = 1'b0;
    int m_pos = 0;
    int m_n   = 4;
    int m_hi  = 2;
    int ms, mq;

    always #10 clk = ~clk;

    outdiv_channel dut (
        .clk(clk), .rst(rst), .out_en(out_en), .set_sel(set_sel),
        .mode_set0(mode_set0), .q_set0(q_set0),
        .mode_set1(mode_set1), .q_set1(q_set1),
        .park_mode(park_mode), .invert(invert),
        .clk_out(clk_out), .drive_en(drive_en)
    );

    function automatic string tag_of();
        if (tag_ovr != "") return tag_ovr;
        if (!m_run) return rst ? "R1" : "R3";
        if (m_byp) return "R4";
        if (m_n == 2) return "R5";
        return "R6";
    endfunction

    function automatic bit exp_drive();
        return m_run ? 1'b1 : park_mode[1];
    endfunction

    function automatic bit exp_level(bit clk_lvl);
        if (!m_run) return park_mode[1] & park_mode[0];
        if (m_byp) return clk_lvl ^ invert;
        return (m_pos < m_hi) ^ invert;
    endfunction

    task automatic compare(bit clk_lvl);
        bit ed, el;
        ed = exp_drive();
        el = exp_level(clk_lvl);
        checks++;
        if (drive_en !== ed || clk_out !== el) begin
            errors++;
            $display("FAIL %s t=%0t drive_en/clk_out actual=%b/%b expected=%b/%b",
                     tag_of(), $time, drive_en, clk_out, ed, el);
        end
    endtask

    always @(posedge clk) begin
        if (rst || !(out_en && mode_set0 != 2'b00 && mode_set1 != 2'b00)) begin
            m_run = 1'b0;
            m_pos = 0;
        end else if (!m_run || m_byp || m_pos == m_n - 1) begin
            ms = set_sel ? int'(mode_set1) : int'(mode_set0);
            mq = set_sel ? int'(q_set1) : int'(q_set0);
            m_byp = (ms == 1);
            m_n   = (ms == 3) ? mq + 2 : (ms == 2) ? 2 : 1;
            m_hi  = m_n / 2;
            m_pos = 0;
            m_run = 1'b1;
        end else begin
            m_pos++;
        end
        #5;
        if (!done) compare(1'b1);
        if (m_run && m_byp) begin
            #10;
            if (!done) compare(1'b0);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(bit en, bit sel, logic [1:0] m0, logic [9:0] q0,
                       logic [1:0] m1, logic [9:0] q1);
        out_en = en; set_sel = sel;
        mode_set0 = m0; q_set0 = q0; mode_set1 = m1; q_set1 = q1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        rst = 1'b1; park_mode = 2'b00; invert = 1'b0;
        cfg(1'b1, 1'b0, 2'b11, 10'd2, 2'b11, 10'd2);
        tag_ovr = "R1";
        cycles(5);
        rst = 1'b0;
        // R3: each park level with channel disabled
        tag_ovr = "R3";
        out_en = 1'b0;
        park_mode = 2'b10; cycles(4);
        park_mode = 2'b11; cycles(4);
        park_mode = 2'b01; cycles(4);
        park_mode = 2'b00; cycles(4);
        // R2: one set with mode off keeps channel parked
        tag_ovr = "R2";
        park_mode = 2'b11;
        cfg(1'b1, 1'b0, 2'b11, 10'd2, 2'b00, 10'd2); cycles(6);
        cfg(1'b1, 1'b0, 2'b00, 10'd2, 2'b10, 10'd2); cycles(6);
        // R9: enabling starts a fresh high phase
        tag_ovr = "R9";
        cfg(1'b1, 1'b0, 2'b11, 10'd2, 2'b11, 10'd5); cycles(13);
        out_en = 1'b0; cycles(3);
        out_en = 1'b1; cycles(9);
        tag_ovr = "";
        // R5, R4, R6 directed
        cfg(1'b1, 1'b0, 2'b10, 10'd0, 2'b11, 10'd0); cycles(10);
        cfg(1'b1, 1'b0, 2'b01, 10'd0, 2'b11, 10'd0); cycles(10);
        cfg(1'b1, 1'b0, 2'b11, 10'd1, 2'b11, 10'd0); cycles(12);
        cfg(1'b1, 1'b0, 2'b11, 10'd0, 2'b11, 10'd0); cycles(8);
        cfg(1'b1, 1'b0, 2'b11, 10'd1023, 2'b11, 10'd0); cycles(2200);
        // R7: inversion on live output, none on parked level
        tag_ovr = "R7";
        invert = 1'b1;
        cfg(1'b1, 1'b0, 2'b11, 10'd3, 2'b11, 10'd3); cycles(15);
        cfg(1'b1, 1'b0, 2'b01, 10'd3, 2'b11, 10'd3); cycles(6);
        out_en = 1'b0; park_mode = 2'b11; cycles(4);
        park_mode = 2'b10; cycles(4);
        invert = 1'b0;
        // R8: mid-period switch waits for period end
        tag_ovr = "R8";
        cfg(1'b1, 1'b0, 2'b11, 10'd6, 2'b10, 10'd0); cycles(10);
        set_sel = 1'b1; cycles(12);
        set_sel = 1'b0; cycles(3);
        q_set0 = 10'd1; cycles(14);
        tag_ovr = "";
        // constrained random segments
        for (int s = 0; s < 80; s++) begin
            int len;
            out_en    = ($urandom % 8) != 0;
            set_sel   = $urandom % 2;
            mode_set0 = ($urandom % 6 == 0) ? 2'b00 : 2'($urandom % 4);
            mode_set1 = ($urandom % 6 == 0) ? 2'b00 : 2'($urandom % 4);
            q_set0    = ($urandom % 10 == 0) ? 10'($urandom) : 10'($urandom % 9);
            q_set1    = ($urandom % 10 == 0) ? 10'($urandom) : 10'($urandom % 9);
            park_mode = 2'($urandom % 4);
            invert    = $urandom % 2;
            len = 30 + int'($urandom % 270);
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                if ($urandom % 40 == 0) set_sel = ~set_sel;
                if ($urandom % 60 == 0) invert = ~invert;
            end
        end
        rst = 1'b1; tag_ovr = "R1"; park_mode = 2'b00; cycles(3);
        finish_run();
    end

endmodule